// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel that sits beside a free-running timer count. It picks one of four capture sources: two external pins and two constant levels. It watches the chosen source for the configured edge and copies the current timer count into its capture register when that edge arrives. Each capture raises a pending flag. An enable bit routes that flag to the interrupt request. If a new capture lands while the flag from the previous one is still set, a sticky overflow flag is raised. Only its own clear strobe resets the overflow flag.

Captures can be immediate or aligned to the timer tick. An immediate capture copies the count on the clock edge where the input change is seen. An aligned capture is held by a two-state controller. In state `ST_IDLE` it waits for an edge. An edge without a tick moves it to `ST_WAIT_TICK` (transition "defer"). The next tick copies the count and returns it to `ST_IDLE` (transition "commit"). An edge that coincides with a tick, or any edge in immediate mode, captures straight from `ST_IDLE` (transition "direct"). Further edges seen in `ST_WAIT_TICK` merge into the one pending capture. Software can force a capture with no external activity: it switches the source select from constant low to constant high.

All inputs are synchronous to `clk`. The external pins must be synchronized outside this block. The previous-level register that feeds edge detection resets to 0.

Top module: `cap_channel`

## Requirements
- R1: With edge mode 00 and no deferred capture pending, no capture happens. The capture value and both flags stay unchanged whatever the source does.
- R2: Edge mode 01 captures on a 0-to-1 change of the selected source. In immediate mode (sync bit 0), the capture value on the following cycle equals the count present in the cycle where the new level first appeared.
- R3: Edge mode 10 captures on a 1-to-0 change of the selected source and ignores 0-to-1 changes.
- R4: Edge mode 11 captures on both kinds of change.
- R5: The source select picks the pin A for 00, the pin B for 01, constant 0 for 10 and constant 1 for 11. The level readback output always shows the selected source.
- R6: With the sync bit at 1, a capture happens only in a cycle where tick is high. An edge seen without a tick is held until the first later cycle with tick high, and that cycle's count is stored.
- R7: Every capture sets the capture flag. The flag-clear strobe clears it. A capture in the same cycle as the clear leaves the flag set.
- R8: A capture that occurs while the capture flag is already set sets the overflow flag and still overwrites the capture value. The overflow flag stays set through flag clears and further captures, and only the overflow-clear strobe resets it.
- R9: The interrupt request is high exactly when the capture flag is set and the interrupt enable is 1.
- R10: With edge mode 01, changing the source select from 10 to 11 produces a capture.
- R11: After reset the capture value is 0, both flags and the interrupt request are 0, and the controller is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer tick qualifier for aligned captures |
| count | input | CNT_W | Current timer count |
| pin_a | input | 1 | Capture source 00 |
| pin_b | input | 1 | Capture source 01 |
| edge_mode | input | 2 | 00 off, 01 rising, 10 falling, 11 both |
| src_sel | input | 2 | 00 pin A, 01 pin B, 10 low, 11 high |
| sync_en | input | 1 | 1 aligns captures to tick |
| irq_en | input | 1 | Routes capture flag to interrupt |
| clr_flag | input | 1 | Clears the capture flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| cap_value | output | CNT_W | Captured count |
| cap_flag | output | 1 | Capture pending |
| ovf_flag | output | 1 | Capture overflow, sticky |
| src_level | output | 1 | Selected source level |
| irq | output | 1 | Interrupt request |

## Verification
A controller stuck in `ST_WAIT_TICK` shows up at the first tick. The capture value and flag change there, although no edge was applied. A controller that never leaves `ST_WAIT_TICK` swallows every later edge, so the capture flag stays low one cycle after an edge where it should be high. A wrong previous-level register shows within one cycle of a source change, as a missed or spurious capture. Flag faults show at the ports on the cycle after a capture or a clear: an overflow that is not sticky, or one raised without a prior flag.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_WAIT_TICK
    } cap_state_e;

    localparam logic [1:0] EDGE_OFF  = 2'b00;
    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_FALL = 2'b10;
    localparam logic [1:0] EDGE_BOTH = 2'b11;

    localparam logic [1:0] SRC_PIN_A = 2'b00;
    localparam logic [1:0] SRC_PIN_B = 2'b01;
    localparam logic [1:0] SRC_LOW   = 2'b10;
    localparam logic [1:0] SRC_HIGH  = 2'b11;
endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_a,
    input  logic       pin_b,
    input  logic [1:0] src_sel,
    input  logic [1:0] edge_mode,
    output logic       level,
    output logic       edge_hit
);
    logic prev_q;
    logic rise;
    logic fall;

    // source mux (R5)
    always_comb begin
        unique case (src_sel)
            SRC_PIN_A: level = pin_a;
            SRC_PIN_B: level = pin_b;
            SRC_LOW:   level = 1'b0;
            SRC_HIGH:  level = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;

    // edge qualification (R1..R4)
    always_comb begin
        unique case (edge_mode)
            EDGE_OFF:  edge_hit = 1'b0;
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
        endcase
    end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       edge_hit,
    input  logic       sync_en,
    input  logic       tick,
    output cap_state_e state_q,
    output logic       cap_ev
);
    cap_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and capture strobe (R6)
    always_comb begin
        state_d = state_q;
        cap_ev  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (edge_hit) begin
                    if (!sync_en || tick) cap_ev = 1'b1;    // direct
                    else                  state_d = ST_WAIT_TICK; // defer
                end
            end
            ST_WAIT_TICK: begin
                if (tick) begin                              // commit
                    cap_ev  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
        endcase
    end
endmodule

// File: rtl/cap_flags.sv
module cap_flags #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_ev,
    input  logic [CNT_W-1:0] count,
    input  logic             clr_flag,
    input  logic             clr_ovf,
    input  logic             irq_en,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag,
    output logic             ovf_flag,
    output logic             irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_value <= '0;
            cap_flag  <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            if (cap_ev)        cap_value <= count;
            if (cap_ev)        cap_flag  <= 1'b1;   // set wins (R7)
            else if (clr_flag) cap_flag  <= 1'b0;
            if (cap_ev && cap_flag) ovf_flag <= 1'b1; // R8
            else if (clr_ovf)       ovf_flag <= 1'b0;
        end
    end

    assign irq = cap_flag & irq_en;
endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic [1:0]       edge_mode,
    input  logic [1:0]       src_sel,
    input  logic             sync_en,
    input  logic             irq_en,
    input  logic             clr_flag,
    input  logic             clr_ovf,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag,
    output logic             ovf_flag,
    output logic             src_level,
    output logic             irq
);
    logic       edge_hit;
    logic       cap_ev;
    cap_state_e state_q;

    cap_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
        .src_sel(src_sel), .edge_mode(edge_mode),
        .level(src_level), .edge_hit(edge_hit)
    );

    cap_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit), .sync_en(sync_en),
        .tick(tick), .state_q(state_q), .cap_ev(cap_ev)
    );

    cap_flags #(.CNT_W(CNT_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .cap_ev(cap_ev), .count(count),
        .clr_flag(clr_flag), .clr_ovf(clr_ovf), .irq_en(irq_en),
        .cap_value(cap_value), .cap_flag(cap_flag), .ovf_flag(ovf_flag),
        .irq(irq)
    );
endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk
    import cap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic [1:0]       edge_mode,
    input logic             irq_en,
    input logic             clr_ovf,
    input logic             cap_ev,
    input cap_state_e       state_q,
    input logic [CNT_W-1:0] cap_value,
    input logic             cap_flag,
    input logic             ovf_flag,
    input logic             irq
);
    a_r1_off_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode == EDGE_OFF && state_q == ST_IDLE) |-> !cap_ev);

    a_r1_value_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_ev |=> $stable(cap_value));

    a_r2_value_is_count: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> cap_value == $past(count));

    a_r6_wait_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_TICK && !tick) |-> !cap_ev);

    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> cap_flag);

    a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_ev && cap_flag) |=> ovf_flag);

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

bind cap_channel cap_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
    .edge_mode(edge_mode), .irq_en(irq_en), .clr_ovf(clr_ovf),
    .cap_ev(cap_ev), .state_q(state_q), .cap_value(cap_value),
    .cap_flag(cap_flag), .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/sim_cap_channel.sv
`timescale 1ns/1ps
module sim_cap_channel;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic [CNT_W-1:0] cnt = '0;
    logic             pin_a = 1'b0, pin_b = 1'b0;
    logic [1:0]       edge_mode = 2'b00, src_sel = 2'b10;
    logic             sync_en = 1'b0, irq_en = 1'b0;
    logic             clr_flag = 1'b0, clr_ovf = 1'b0;
    logic [CNT_W-1:0] cap_value;
    logic             cap_flag, ovf_flag, src_level, irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [CNT_W-1:0] exp_v;

    always #5 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 16'd1;

    cap_channel #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(cnt),
        .pin_a(pin_a), .pin_b(pin_b), .edge_mode(edge_mode), .src_sel(src_sel),
        .sync_en(sync_en), .irq_en(irq_en), .clr_flag(clr_flag), .clr_ovf(clr_ovf),
        .cap_value(cap_value), .cap_flag(cap_flag), .ovf_flag(ovf_flag),
        .src_level(src_level), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_clr_flag();
        clr_flag = 1'b1; step(1); clr_flag = 1'b0;
    endtask

    task automatic pulse_clr_ovf();
        clr_ovf = 1'b1; step(1); clr_ovf = 1'b0;
    endtask

    task automatic t_reset();
        step(1);
        check("R11 value", 32'(cap_value), 0);
        check("R11 flag", 32'(cap_flag), 0);
        check("R11 ovf", 32'(ovf_flag), 0);
        check("R11 irq", 32'(irq), 0);
        rst_n = 1'b1;
        step(2);
        check("R11 no capture after release", 32'(cap_flag), 0);
    endtask

    task automatic t_off();
        edge_mode = 2'b00; src_sel = 2'b00;
        step(1);
        pin_a = 1'b1; step(2);
        pin_a = 1'b0; step(2);
        check("R1 value held", 32'(cap_value), 0);
        check("R1 flag low", 32'(cap_flag), 0);
    endtask

    task automatic t_rise();
        edge_mode = 2'b01; src_sel = 2'b00;
        step(1);
        pin_a = 1'b1; exp_v = cnt;
        step(1);
        check("R2 rise value", 32'(cap_value), 32'(exp_v));
        check("R2 rise flag", 32'(cap_flag), 1);
        pulse_clr_flag();
        check("R7 clear", 32'(cap_flag), 0);
        pin_a = 1'b0; step(2);
        check("R2 fall ignored", 32'(cap_flag), 0);
        check("R2 value kept", 32'(cap_value), 32'(exp_v));
    endtask

    task automatic t_fall();
        edge_mode = 2'b10; src_sel = 2'b01; pin_b = 1'b0;
        step(2);
        pin_b = 1'b1; step(2);
        check("R3 rise ignored", 32'(cap_flag), 0);
        pin_b = 1'b0; exp_v = cnt;
        step(1);
        check("R3 fall value", 32'(cap_value), 32'(exp_v));
        check("R3 fall flag", 32'(cap_flag), 1);
        pulse_clr_flag();
    endtask

    task automatic t_both_ovf();
        edge_mode = 2'b11; src_sel = 2'b00; pin_a = 1'b0;
        step(2);
        pin_a = 1'b1; step(1);
        check("R4 rise flag", 32'(cap_flag), 1);
        check("R8 no ovf yet", 32'(ovf_flag), 0);
        step(1);
        pin_a = 1'b0; exp_v = cnt;
        step(1);
        check("R4 fall value", 32'(cap_value), 32'(exp_v));
        check("R8 ovf set", 32'(ovf_flag), 1);
        pulse_clr_flag();
        step(2);
        check("R8 ovf sticky", 32'(ovf_flag), 1);
        pulse_clr_ovf();
        check("R8 ovf cleared", 32'(ovf_flag), 0);
    endtask

    task automatic t_same_cycle();
        edge_mode = 2'b01; src_sel = 2'b00; pin_a = 1'b0;
        step(2);
        pin_a = 1'b1; clr_flag = 1'b1;
        step(1);
        clr_flag = 1'b0;
        check("R7 set beats clear", 32'(cap_flag), 1);
        check("R7 no ovf", 32'(ovf_flag), 0);
        pulse_clr_flag();
        pin_a = 1'b0; step(1);
    endtask

    task automatic t_select();
        edge_mode = 2'b00; pin_a = 1'b1; pin_b = 1'b0;
        src_sel = 2'b00; #1 check("R5 sel A", 32'(src_level), 1);
        src_sel = 2'b01; #1 check("R5 sel B", 32'(src_level), 0);
        src_sel = 2'b10; #1 check("R5 sel low", 32'(src_level), 0);
        src_sel = 2'b11; #1 check("R5 sel high", 32'(src_level), 1);
        step(2);
        check("R1 sel changes no capture", 32'(cap_flag), 0);
        pin_a = 1'b0;
    endtask

    task automatic t_sync();
        edge_mode = 2'b01; src_sel = 2'b00; sync_en = 1'b1; tick = 1'b0;
        step(2);
        exp_v = cap_value;
        pin_a = 1'b1; step(3);
        check("R6 held flag", 32'(cap_flag), 0);
        check("R6 held value", 32'(cap_value), 32'(exp_v));
        tick = 1'b1; exp_v = cnt;
        step(1);
        tick = 1'b0;
        check("R6 tick value", 32'(cap_value), 32'(exp_v));
        check("R6 tick flag", 32'(cap_flag), 1);
        pulse_clr_flag();
        tick = 1'b1; step(2); tick = 1'b0;
        check("R6 single capture", 32'(cap_flag), 0);
        pin_a = 1'b0; sync_en = 1'b0; step(1);
    endtask

    task automatic t_soft();
        edge_mode = 2'b01; src_sel = 2'b10;
        step(2);
        src_sel = 2'b11; exp_v = cnt;
        step(1);
        check("R10 soft value", 32'(cap_value), 32'(exp_v));
        check("R10 soft flag", 32'(cap_flag), 1);
    endtask

    task automatic t_irq();
        irq_en = 1'b0; #1
        check("R9 disabled", 32'(irq), 0);
        irq_en = 1'b1; #1
        check("R9 enabled", 32'(irq), 1);
        pulse_clr_flag();
        check("R9 flag low", 32'(irq), 0);
        irq_en = 1'b0;
    endtask

    bit done = 0;
    initial begin
        t_reset();
        t_off();
        t_rise();
        t_fall();
        t_both_ovf();
        t_same_cycle();
        t_select();
        t_sync();
        t_soft();
        t_irq();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule